// File: doc/BRIEF.md
# Serial DAC Write Front End

This block is the digital receive side of a 12-bit voltage-output converter. A host drives three wires: an active-low frame strobe, a serial clock and a data line. The block samples all three with a faster system clock, builds a 16-bit word most significant bit first, and on the sixteenth falling serial-clock edge loads a 12-bit converter code and a 2-bit operating mode together.

The mode selects normal operation or one of three power-down terminations for the analog output: 5k to ground, 100k to ground, or high impedance. It is presented as a power-down flag and as one-hot termination enables. A frame that ends before its sixteenth bit is dropped and reported by a one-cycle abort pulse. Each commit is marked by a one-cycle update pulse. Reset stands in for the power-on circuit and leaves the code at zero in normal mode.

The system clock must run at least four times the serial clock rate. Each serial-clock half period must last at least two system clocks.

Top module: `dac_serial_front`

## Requirements
- R1: After reset, code_o is 0, mode_o is 00, pwr_down_o and all three termination outputs are 0, and neither pulse output is high.
- R2: While the strobe is low, data is shifted in on each falling serial-clock edge, most significant bit first. On the 16th edge, bits 11..0 load code_o and bits 13..12 load mode_o in the same cycle.
- R3: Mode decodes as 00 normal (no termination, pwr_down_o=0), 01 to term_5k_o, 10 to term_100k_o, and 11 to term_hiz_o. pwr_down_o is 1 for any nonzero mode, and at most one termination output is high.
- R4: Frame bits 15 and 14 have no effect on code_o or mode_o.
- R5: If the strobe rises before the 16th falling edge, code_o and mode_o keep their values, no update pulse occurs, and abort_o pulses once.
- R6: After an aborted frame, the next complete frame loads correctly, because the bit count restarts from zero.
- R7: After a commit with the strobe still low, further serial-clock edges are ignored until the strobe goes high and falls again. The later strobe rise produces no abort.
- R8: update_o and abort_o are each high for exactly one system-clock cycle per event.
- R9: code_o and mode_o change only in a cycle where update_o is high.
- R10: If the strobe rise and the 16th falling edge are seen in the same sampled cycle, the frame commits and no abort occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| frame_n_i | input | 1 | Active-low frame strobe |
| sclk_i | input | 1 | Serial clock; data is taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| code_o | output | 12 | Committed converter code |
| mode_o | output | 2 | Committed operating mode |
| pwr_down_o | output | 1 | Any power-down mode is active |
| term_5k_o | output | 1 | 5k pull-down enable |
| term_100k_o | output | 1 | 100k pull-down enable |
| term_hiz_o | output | 1 | High-impedance output enable |
| update_o | output | 1 | One-cycle pulse on commit |
| abort_o | output | 1 | One-cycle pulse on a short frame |

## Verification
Two events can fall in the same sampled cycle: the strobe rising, which would abort the frame, and the sixteenth serial-clock fall, which would commit it. The bench provokes this by moving both wires on the same system-clock edge. Both pass through synchronizers of equal depth, so the block sees the two edges together. The result is judged at the ports: the new code and mode must appear, the update count must rise by one, and the abort count must not change.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned MODE_W = 2;
  localparam int unsigned PAD_W  = 2;
  localparam int unsigned WORD_W = PAD_W + MODE_W + CODE_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_RUN     = 2'b00,
    MODE_PD_5K   = 2'b01,
    MODE_PD_100K = 2'b10,
    MODE_PD_HIZ  = 2'b11
  } op_mode_e;
endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] pipe_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= RST_VAL;
      else if (s == 0) pipe_q[s] <= async_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else prev_q <= pipe_q[STAGES-1];
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign fall_o = prev_q & ~pipe_q[STAGES-1];
endmodule

// File: rtl/dac_fe_frame.sv
module dac_fe_frame #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_lvl_i,
  input  logic              frame_fall_i,
  input  logic              sclk_fall_i,
  input  logic              sdata_i,
  output logic              commit_o,
  output logic              abort_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              armed_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] shreg_q;
  logic              commit, abort, shift;

  // last edge wins over a coincident strobe rise
  assign commit = armed_q & sclk_fall_i & (cnt_q == LAST);
  assign abort  = armed_q & frame_lvl_i & ~commit;
  assign shift  = armed_q & sclk_fall_i & ~frame_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (frame_fall_i) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (commit || abort) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (shift) begin
      cnt_q   <= cnt_q + 1'b1;
      shreg_q <= {shreg_q[WORD_W-3:0], sdata_i};
    end
  end

  assign commit_o = commit;
  assign abort_o  = abort;
  assign word_o   = {shreg_q, sdata_i};
endmodule

// File: rtl/dac_fe_decode.sv
module dac_fe_decode
  import dac_fe_pkg::*;
(
  input  op_mode_e mode_i,
  output logic     pwr_down_o,
  output logic     term_5k_o,
  output logic     term_100k_o,
  output logic     term_hiz_o
);
  always_comb begin
    term_5k_o   = 1'b0;
    term_100k_o = 1'b0;
    term_hiz_o  = 1'b0;
    unique case (mode_i)
      MODE_PD_5K:   term_5k_o   = 1'b1;
      MODE_PD_100K: term_100k_o = 1'b1;
      MODE_PD_HIZ:  term_hiz_o  = 1'b1;
      default: ;
    endcase
  end
  assign pwr_down_o = (mode_i != MODE_RUN);
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_fe_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              pwr_down_o,
  output logic              term_5k_o,
  output logic              term_100k_o,
  output logic              term_hiz_o,
  output logic              update_o,
  output logic              abort_o
);
  // lane order: {frame, sclk, data}; strobe idles high
  logic [2:0] lvl, fall;
  logic [WORD_W-1:0] word;
  logic commit, abort;
  logic [CODE_W-1:0] code_q;
  op_mode_e mode_q;
  logic upd_q, abt_q;

  dac_fe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .async_i({frame_n_i, sclk_i, sdata_i}),
    .lvl_o(lvl), .fall_o(fall)
  );

  dac_fe_frame #(.WORD_W(WORD_W)) u_frame (
    .clk_i, .rst_ni,
    .frame_lvl_i(lvl[2]), .frame_fall_i(fall[2]),
    .sclk_fall_i(fall[1]), .sdata_i(lvl[0]),
    .commit_o(commit), .abort_o(abort), .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mode_q <= MODE_RUN;
      upd_q  <= 1'b0;
      abt_q  <= 1'b0;
    end else begin
      upd_q <= commit;
      abt_q <= abort;
      if (commit) begin
        code_q <= word[CODE_W-1:0];
        mode_q <= op_mode_e'(word[CODE_W +: MODE_W]);
      end
    end
  end

  dac_fe_decode u_dec (
    .mode_i(mode_q), .pwr_down_o, .term_5k_o, .term_100k_o, .term_hiz_o
  );

  assign code_o   = code_q;
  assign mode_o   = mode_q;
  assign update_o = upd_q;
  assign abort_o  = abt_q;
endmodule

// File: rtl/dac_fe_chk.sv
module dac_fe_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [11:0] code_o,
  input logic [1:0]  mode_o,
  input logic        pwr_down_o,
  input logic        term_5k_o,
  input logic        term_100k_o,
  input logic        term_hiz_o,
  input logic        update_o,
  input logic        abort_o
);
  AST_UPD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) update_o |=> !update_o); // R8
  AST_ABT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) abort_o |=> !abort_o); // R8
  AST_UPD_ABT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni) !(update_o && abort_o)); // R10
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !update_o |-> $stable(code_o)); // R9
  AST_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni) !update_o |-> $stable(mode_o)); // R9
  AST_ABT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni) abort_o |-> $stable(code_o) && $stable(mode_o)); // R5
  AST_TERM_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({term_5k_o, term_100k_o, term_hiz_o})); // R3
  AST_PD_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni) pwr_down_o == ($countones({term_5k_o, term_100k_o, term_hiz_o}) == 1)); // R3
endmodule

bind dac_serial_front dac_fe_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .code_o(code_o), .mode_o(mode_o),
  .pwr_down_o(pwr_down_o), .term_5k_o(term_5k_o), .term_100k_o(term_100k_o),
  .term_hiz_o(term_hiz_o), .update_o(update_o), .abort_o(abort_o)
);

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0;
  logic frame_n = 1, sclk = 0, sdata = 0;
  logic [11:0] code;
  logic [1:0] mode;
  logic pd, t5, t100, thz, upd, abt;

  int checks = 0, fails = 0;
  int upd_cnt = 0, abt_cnt = 0, wide = 0, glitch = 0;
  logic upd_p = 0, abt_p = 0;
  logic [11:0] code_p = 0;
  logic [1:0] mode_p = 0;

  always #4 clk = ~clk;

  dac_serial_front dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_n_i(frame_n), .sclk_i(sclk), .sdata_i(sdata),
    .code_o(code), .mode_o(mode), .pwr_down_o(pd), .term_5k_o(t5), .term_100k_o(t100),
    .term_hiz_o(thz), .update_o(upd), .abort_o(abt)
  );

  always @(negedge clk) if (rst_n) begin
    if (upd) upd_cnt++;
    if (abt) abt_cnt++;
    if ((upd && upd_p) || (abt && abt_p)) wide++;
    if (!upd && (code != code_p || mode != mode_p)) glitch++;
    upd_p = upd; abt_p = abt; code_p = code; mode_p = mode;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input bit keep_low);
    @(negedge clk); frame_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdata = w[15-i]; sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
      repeat (HALF) @(negedge clk);
    end
    if (!keep_low) frame_n = 1;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 code", code, 0);
    check("R1 mode", mode, 0);
    check("R1 flags", {pd, t5, t100, thz, upd, abt}, 0);
  endtask

  task automatic t_modes();
    logic [15:0] w;
    for (int m = 0; m < 4; m++) begin
      int u0 = upd_cnt;
      w = {2'b00, 2'(m), 12'h1A5 + 12'(m * 257)};
      send(w, 16, 0);
      check("R2 code", code, w[11:0]);
      check("R2 mode", mode, m);
      check("R3 decode", {pd, t5, t100, thz},
            {m != 0, m == 1, m == 2, m == 3});
      check("R8 update count", upd_cnt - u0, 1);
    end
  endtask

  task automatic t_dont_care();
    send(16'hC555, 16, 0);
    check("R4 code", code, 12'h555);
    check("R4 mode", mode, 0);
  endtask

  task automatic t_short();
    int u0 = upd_cnt, a0 = abt_cnt;
    send(16'h2ABC, 16, 0);
    send(16'h1FFF, 9, 0);
    check("R5 code kept", code, 12'hABC);
    check("R5 mode kept", mode, 2);
    check("R5 abort count", abt_cnt - a0, 1);
    check("R5 no update", upd_cnt - u0, 1);
    send(16'h3123, 16, 0);
    check("R6 code", code, 12'h123);
    check("R6 mode", mode, 3);
  endtask

  task automatic t_hold_low();
    int u0 = upd_cnt, a0 = abt_cnt;
    send(16'h1456, 16, 1);
    for (int i = 0; i < 16; i++) begin
      sdata = 1; sclk = 1; repeat (HALF) @(negedge clk);
      sclk = 0; repeat (HALF) @(negedge clk);
    end
    frame_n = 1;
    repeat (12) @(negedge clk);
    check("R7 code", code, 12'h456);
    check("R7 mode", mode, 1);
    check("R7 one update", upd_cnt - u0, 1);
    check("R7 no abort", abt_cnt - a0, 0);
  endtask

  task automatic t_coincide();
    logic [15:0] w = 16'h2E01;
    int u0 = upd_cnt, a0 = abt_cnt;
    @(negedge clk); frame_n = 0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      sdata = w[15-i]; sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
      if (i == 15) frame_n = 1;
      repeat (HALF) @(negedge clk);
    end
    repeat (12) @(negedge clk);
    check("R10 code", code, 12'hE01);
    check("R10 mode", mode, 2);
    check("R10 update", upd_cnt - u0, 1);
    check("R10 no abort", abt_cnt - a0, 0);
  endtask

  task automatic t_pulses();
    check("R8 pulse width", wide, 0);
    check("R9 change without update", glitch, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_modes();
    t_dont_care();
    t_short();
    t_hold_low();
    t_coincide();
    t_pulses();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule